// File: doc/BRIEF.md
# Reloadable Down-Counting Tick Timer

This block produces a regular tick for scheduling software. A 24-bit counter counts down one step per count cycle. After it reaches zero, the next count cycle reloads it from a programmable reload register. The tick period is therefore the reload value plus one count cycle. Each arrival at zero sets a sticky count flag. If interrupts are enabled, it also raises a one-cycle interrupt request.

Three count sources are available. The first steps on every core clock. The second steps once every `DIV_RATIO` core clocks. The third steps on the rising edges of an external reference, which is first synchronised into the core clock domain.

Software reaches the timer through a simple single-cycle register port with three registers:

- A control/status register. Reading it returns the count flag and clears the flag.
- A reload register.
- A current-value register. Any write to it zeroes the counter, so the next count cycle reloads it.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control/status, reload and current-value registers read as zero, and `irq` is low.
- R2: With the core clock selected (source field 0 or 3) and the run bit set, the counter drops by one on every clock. From zero it loads the reload value, so successive `irq` pulses are reload+1 clocks apart.
- R3: With source field 1, the counter steps once every `DIV_RATIO` core clocks. The divider is free-running from reset.
- R4: With source field 2, each rising edge of `ext_ref` gives one count step. The count changes on the third rising clock edge after `ext_ref` is first sampled high.
- R5: While the run bit (control bit 0) is clear, the counter holds its value.
- R6: Each transition of the counter from one to zero sets the count flag, which reads back at control bit 16. A read of the control/status register clears the flag one clock later. A transition in the same clock wins over the clear.
- R7: `irq` pulses high for one clock, in the clock after each transition to zero, only while the interrupt enable (control bit 1) is set. With the enable clear, the flag still sets and `irq` stays low.
- R8: A write of any value to the current-value register (address 2) sets the counter to zero and clears the flag. It overrides a count step in the same clock.
- R9: With a reload value of zero, a counter at zero stays at zero and produces neither flag nor `irq`.
- R10: The register map is: address 0 is control/status, with run at bit 0, interrupt enable at bit 1, source at bits 3:2 and flag at bit 16. Address 1 is reload. Address 2 is current value. Address 3 reads as zero.
- R11: The reload register keeps only the low 24 bits written; upper write-data bits are ignored and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_ref | input | 1 | External count reference, asynchronous to clk |
| bus_sel | input | 1 | Register access strobe, one access per clock |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | One-clock interrupt request on each wrap |

## Verification
The assertions assume that a read has a side effect only at address 0. The bench therefore idles the port as a continuous read of the current-value register, which lets it observe the count on every clock without disturbing the flag.

The edge-spacing checks assume `ext_ref` holds each level for at least one full clock, and the stimulus only changes it one time unit after a rising clock edge. Register writes are issued one per clock and never overlap a read, matching the single-access port the checks rely on.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic [1:0] {
    SRC_CORE     = 2'd0,
    SRC_DIV      = 2'd1,
    SRC_EXT      = 2'd2,
    SRC_CORE_ALT = 2'd3
  } tick_src_e;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_CUR    = 2'd2;
  localparam int         FLAG_BIT    = 16;
endpackage

// File: rtl/tick_src.sv
module tick_src
  import tick_timer_pkg::*;
#(
  parameter int DIV_RATIO = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ext_ref,
  input  tick_src_e src,
  input  logic      run,
  output logic      tick_en
);
  localparam int PS_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(DIV_RATIO - 1);

  logic [PS_W-1:0] ps_q;
  logic            sync1_q, sync2_q, prev_q;
  logic            ext_edge;
  logic            div_stb;
  logic            src_tick;

  // Prescaler: runs freely from reset, whether or not the timer is enabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ps_q <= '0;
    else if (ps_q == PS_LAST) ps_q <= '0;
    else ps_q <= ps_q + PS_W'(1);
  end
  assign div_stb = (ps_q == PS_LAST);

  // External reference: two-flop synchroniser, then a delay flop for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= ext_ref;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end
  assign ext_edge = sync2_q & ~prev_q;

  always_comb begin
    case (src)
      SRC_DIV: src_tick = div_stb;
      SRC_EXT: src_tick = ext_edge;
      default: src_tick = 1'b1;
    endcase
  end
  assign tick_en = run & src_tick;

  // R4
  ext_edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_edge |=> !ext_edge);
  // R3
  div_stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_stb |=> !div_stb);
endmodule

// File: rtl/tick_count.sv
module tick_count #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cur_wr,
  input  logic             flag_rd,
  input  logic             irq_en,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             flag,
  output logic             irq
);
  // Next value for one count step: reload from zero, otherwise decrement.
  function automatic logic [CNT_W-1:0] step_val(input logic [CNT_W-1:0] cur,
                                                input logic [CNT_W-1:0] rl);
    return (cur == '0) ? rl : cur - CNT_W'(1);
  endfunction

  logic zero_evt;
  assign zero_evt = tick_en & ~cur_wr & (count == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      flag  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (cur_wr)       count <= '0;
      else if (tick_en) count <= step_val(count, reload);
      if (zero_evt)                flag <= 1'b1;
      else if (cur_wr || flag_rd)  flag <= 1'b0;
      irq <= zero_evt & irq_en;
    end
  end

  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cur_wr) |=> $stable(count));
  // R7
  irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count == '0));
  // R6
  flag_rise_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (count == '0));
  // R8
  cur_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_wr |=> (count == '0) && !flag);
  // R9
  zero_reload_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((count == '0) && (reload == '0)) |=> (count == '0) && !irq);
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              flag,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              run,
  output logic              irq_en,
  output tick_src_e         src,
  output logic [CNT_W-1:0]  reload,
  output logic              cur_wr,
  output logic              flag_rd
);
  logic ctrl_wr, reload_wr;

  assign ctrl_wr   = bus_sel &  bus_wr & (bus_addr == ADDR_CTRL);
  assign reload_wr = bus_sel &  bus_wr & (bus_addr == ADDR_RELOAD);
  assign cur_wr    = bus_sel &  bus_wr & (bus_addr == ADDR_CUR);
  assign flag_rd   = bus_sel & ~bus_wr & (bus_addr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      irq_en <= 1'b0;
      src    <= SRC_CORE;
      reload <= '0;
    end else begin
      if (ctrl_wr) begin
        run    <= bus_wdata[0];
        irq_en <= bus_wdata[1];
        src    <= tick_src_e'(bus_wdata[3:2]);
      end
      if (reload_wr) reload <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_CTRL: begin
        bus_rdata[0]        = run;
        bus_rdata[1]        = irq_en;
        bus_rdata[3:2]      = src;
        bus_rdata[FLAG_BIT] = flag;
      end
      ADDR_RELOAD: bus_rdata[CNT_W-1:0] = reload;
      ADDR_CUR:    bus_rdata[CNT_W-1:0] = count;
      default:     bus_rdata = '0;
    endcase
  end

  // R10
  one_access_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ctrl_wr, reload_wr, cur_wr, flag_rd}) <= 1);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int DATA_W    = 32,
  parameter int DIV_RATIO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_ref,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic             run, irq_en, cur_wr, flag_rd, tick_en, flag;
  tick_src_e        src;
  logic [CNT_W-1:0] reload, count;

  tick_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .flag(flag), .count(count),
    .bus_rdata(bus_rdata), .run(run), .irq_en(irq_en), .src(src),
    .reload(reload), .cur_wr(cur_wr), .flag_rd(flag_rd)
  );

  tick_src #(.DIV_RATIO(DIV_RATIO)) u_src (
    .clk(clk), .rst_n(rst_n), .ext_ref(ext_ref), .src(src), .run(run),
    .tick_en(tick_en)
  );

  tick_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cur_wr(cur_wr),
    .flag_rd(flag_rd), .irq_en(irq_en), .reload(reload), .count(count),
    .flag(flag), .irq(irq)
  );
endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  localparam int DIV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_ref = 1'b0;
  logic        bus_sel = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int    checks = 0;
  int    errors = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  tick_timer u_tick_timer (
    .clk(clk), .rst_n(rst_n), .ext_ref(ext_ref), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // Behavioural reference model
  longint mcnt, mrel;
  bit     mrun, mie, mflag, mirq;
  int     msrc, mps;
  bit     hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt = 0; mrel = 0; mrun = 0; mie = 0; mflag = 0; mirq = 0;
      msrc = 0; mps = 0;
      hist = '{0, 0, 0};
    end else begin
      bit srct, tick, wcur, rctl, zev;
      if (msrc == 1)      srct = (mps == DIV - 1);
      else if (msrc == 2) srct = hist[1] && !hist[2];
      else                srct = 1;
      tick = mrun && srct;
      wcur = bus_sel && bus_wr && bus_addr == 2;
      rctl = bus_sel && !bus_wr && bus_addr == 0;
      zev  = tick && !wcur && mcnt == 1;
      mirq = zev && mie;
      if (zev) mflag = 1;
      else if (wcur || rctl) mflag = 0;
      if (wcur) mcnt = 0;
      else if (tick) mcnt = (mcnt == 0) ? mrel : mcnt - 1;
      if (bus_sel && bus_wr && bus_addr == 0) begin
        mrun = bus_wdata[0]; mie = bus_wdata[1]; msrc = int'(bus_wdata[3:2]);
      end
      if (bus_sel && bus_wr && bus_addr == 1) mrel = bus_wdata & 32'hFF_FFFF;
      mps = (mps + 1) % DIV;
      hist.push_front(ext_ref);
      void'(hist.pop_back());
    end
  end

  function automatic longint model_rd(input logic [1:0] a);
    case (a)
      2'd0:    return (longint'(mflag) << 16) | (longint'(msrc) << 2) |
                      (longint'(mie) << 1) | longint'(mrun);
      2'd1:    return mrel;
      2'd2:    return mcnt;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(phase, "irq", longint'(irq), longint'(mirq));
      if (bus_sel && !bus_wr)
        check(phase, "rdata", longint'(bus_rdata), model_rd(bus_addr));
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      bus_sel = 1; bus_wr = 0; bus_addr = 2;
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    idle(1);
  endtask

  task automatic rd_reg(input logic [1:0] a);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    idle(1);
  endtask

  task automatic ext_pulses(input int hi, input int lo, input int n);
    repeat (n) begin
      ext_ref = 1; idle(hi);
      ext_ref = 0; idle(lo);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired in phase %s", phase);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int gap;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    @(negedge clk);
    check("R1", "irq", longint'(irq), 0);
    check("R1", "current", longint'(bus_rdata), 0);
    bus_addr = 1; #1;
    check("R1", "reload", longint'(bus_rdata), 0);
    bus_addr = 2;
    idle(1);

    // R11 / R10 register readback
    phase = "R11";
    wr_reg(2'd1, 32'hABCD_EF12);
    rd_reg(2'd1);
    bus_addr = 1; #1;
    check("R11", "reload masked", longint'(bus_rdata), 64'h00CD_EF12);
    bus_addr = 2;
    phase = "R10";
    rd_reg(2'd3);

    // R2 core source, period reload+1
    phase = "R2";
    wr_reg(2'd1, 32'd5);
    wr_reg(2'd2, 32'd0);
    wr_reg(2'd0, 32'h3);
    gap = 0;
    do begin @(negedge clk); end while (!irq);
    do begin @(negedge clk); gap++; end while (!irq && gap < 100);
    check("R2", "irq spacing", gap, 6);
    idle(20);
    wr_reg(2'd0, 32'hF);
    idle(15);

    // R6 flag set and read-clear
    phase = "R6";
    wr_reg(2'd0, 32'h1);
    idle(3);
    rd_reg(2'd0);
    rd_reg(2'd0);
    idle(7);
    rd_reg(2'd0);

    // R7 interrupt disabled: flag only
    phase = "R7";
    idle(20);
    rd_reg(2'd0);
    wr_reg(2'd0, 32'h3);
    idle(14);

    // R5 run clear holds the count
    phase = "R5";
    wr_reg(2'd0, 32'h2);
    idle(12);

    // R8 write to current value while running
    phase = "R8";
    wr_reg(2'd0, 32'h3);
    idle(3);
    wr_reg(2'd2, 32'h123);
    idle(10);

    // R3 divided core clock
    phase = "R3";
    wr_reg(2'd1, 32'd3);
    wr_reg(2'd0, 32'h7);
    idle(120);

    // R4 external reference
    phase = "R4";
    wr_reg(2'd1, 32'd2);
    wr_reg(2'd0, 32'hB);
    ext_pulses(3, 2, 8);
    ext_pulses(1, 1, 10);
    ext_pulses(5, 4, 4);
    idle(6);

    // R9 zero reload halts
    phase = "R9";
    wr_reg(2'd1, 32'd0);
    wr_reg(2'd0, 32'h3);
    wr_reg(2'd2, 32'd0);
    idle(30);
    rd_reg(2'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule